// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block holds the control and status state that decides whether a write may proceed, either to an 8 KB serial memory array or to that memory's status register. It takes strobes for instructions that have already been decoded: enable writes, disable writes, write status, set flag and clear flag. It also takes the byte proposed for the status register, the address of an array write request, the active-low hardware protect pin, a power-on reset and a busy signal from the nonvolatile storage timer. From these it keeps the status byte and issues one-cycle grants for array writes and for status writes.

Two kinds of bits sit behind the protection. The volatile bits are the write-enable latch and a general-purpose flag, and both clear at power-up. The nonvolatile bits are the pin-lock enable, two watchdog bits and a two-bit array lock code. They are modelled as registers that keep their value through the power-on reset.

A status write that has been granted is held pending. The new nonvolatile values are committed when the storage busy signal falls. The pin-lock condition is sampled only when the status write is accepted, so a write already in flight always completes.

Top module: `wprot_ctrl`

## Requirements
- R1: When `por_n` is low on a clock edge, the write-enable latch, the flag, any pending status write and both grants are cleared. The nonvolatile bits (status bits 7, 6:5 and 3:2) keep their values.
- R2: `cmd_wren` sets the write-enable latch and `cmd_wrdi` clears it. If both arrive in the same cycle, the clear takes effect.
- R3: While the write-enable latch is 0, a request on `arr_wr_req` or `cmd_wrsr` produces no grant.
- R4: `arr_wr_grant` pulses for one cycle, in the cycle after a request, exactly when all of these hold: the latch was 1, no status write was pending, and the address lay outside the locked range. The locked range by lock code is: 00 none; 01 0x1800–0x1FFF; 10 0x1000–0x1FFF; 11 the whole array.
- R5: `sr_wr_grant` pulses for one cycle, in the cycle after `cmd_wrsr`, when the latch was 1 and no status write was pending. The one exception is that the request is refused when `wp_n` is low and the pin-lock bit is 1. With the pin-lock bit at 0 the pin level does not matter, and with the pin high the bit does not matter.
- R6: A granted status write completes even if `wp_n` falls while it is in progress.
- R7: On the clock edge where `sr_busy` is seen falling while a status write is pending, these status bits take the captured byte's bits: bit 7 (pin-lock), bits 6:5 (watchdog) and bits 3:2 (lock code). The flag and the write-enable latch are not loaded from the byte.
- R8: `cmd_sflag` sets the flag and `cmd_rflag` clears it. If both arrive in the same cycle, the clear takes effect.
- R9: The write-enable latch clears on the edge that issues an array grant and on the edge that commits a status write.
- R10: The status byte is {pin-lock, watchdog[1:0], flag, lock[1:0], write-enable latch, 0}, most significant bit first.
- R11: While a status write is pending, further status write requests and array write requests get no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| cmd_wren | input | 1 | Decoded write-enable instruction strobe |
| cmd_wrdi | input | 1 | Decoded write-disable instruction strobe |
| cmd_wrsr | input | 1 | Decoded write-status instruction strobe |
| cmd_sflag | input | 1 | Decoded set-flag instruction strobe |
| cmd_rflag | input | 1 | Decoded clear-flag instruction strobe |
| sr_wdata | input | 8 | Proposed status byte, valid with `cmd_wrsr` |
| arr_wr_req | input | 1 | Array write request strobe |
| arr_addr | input | ADDR_W | Target array address, valid with `arr_wr_req` |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| sr_busy | input | 1 | Nonvolatile status write in progress |
| status_o | output | 8 | Current status byte |
| arr_wr_grant | output | 1 | One-cycle grant for an array write |
| sr_wr_grant | output | 1 | One-cycle grant for a status write |

## Verification
Array requests are made under each of the four lock codes at addresses on both sides of each range boundary: 0x17FF against 0x1800, 0x0FFF against 0x1000, and 0x0000 and 0x1FFF under full lock. This separates an off-by-one range decode from a wrong code mapping. Status writes are tried with all four combinations of pin level and pin-lock bit, and the pin is dropped while a write is in flight. This separates a lock that is sampled at acceptance from one that is evaluated at commit. Coincident set/clear strobes, requests made while a write is pending, and a power-on reset that follows committed nonvolatile changes each isolate one priority rule or retention rule.

// File: rtl/wpc_pkg.sv
// Package: shared field positions and types for the write-protection controller.
// Assumes an 8-bit status byte laid out {pin-lock, wdog[1:0], flag, lock[1:0], wel, 0}.
package wpc_pkg;

    localparam int STAT_W    = 8;
    localparam int POS_PLOCK = 7;
    localparam int POS_WD_LO = 5;
    localparam int POS_FLAG  = 4;
    localparam int POS_LK_LO = 2;
    localparam int POS_WEL   = 1;

    typedef enum logic [1:0] {
        LOCK_NONE     = 2'b00,
        LOCK_TOP_QTR  = 2'b01,
        LOCK_TOP_HALF = 2'b10,
        LOCK_ALL      = 2'b11
    } lock_code_e;

    typedef struct packed {
        logic       plock;
        logic [1:0] wdog;
        lock_code_e lock;
    } nv_bits_t;

    // Extract the nonvolatile fields from a proposed status byte.
    function automatic nv_bits_t nv_from_byte(input logic [STAT_W-1:0] b);
        nv_bits_t n;
        n.plock = b[POS_PLOCK];
        n.wdog  = b[POS_WD_LO +: 2];
        n.lock  = lock_code_e'(b[POS_LK_LO +: 2]);
        return n;
    endfunction

endpackage

// File: rtl/wpc_vol_latches.sv
// Volatile state: write-enable latch and general flag.
// Assumes clear requests take priority over set requests in the same cycle.
module wpc_vol_latches (
    input  logic clk,
    input  logic rst_n,
    input  logic wel_set,
    input  logic wel_clr,
    input  logic flag_set,
    input  logic flag_clr,
    output logic wel,
    output logic flag
);

    logic wel_q;
    logic flag_q;

    // Update both volatile bits; clear wins, both drop at power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wel_clr)       wel_q <= 1'b0;
            else if (wel_set)  wel_q <= 1'b1;
            if (flag_clr)      flag_q <= 1'b0;
            else if (flag_set) flag_q <= 1'b1;
        end
    end

    assign wel  = wel_q;
    assign flag = flag_q;

endmodule

// File: rtl/wpc_range_check.sv
// Combinational decode: is an array address inside the range selected by the lock code?
// Assumes ADDR_W >= 2; ranges are the top quarter, the top half or the whole array.
module wpc_range_check
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  lock_code_e        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int MSB = ADDR_W - 1;

    // Select the protected region from the two top address bits.
    always_comb begin
        unique case (code)
            LOCK_NONE:     hit = 1'b0;
            LOCK_TOP_QTR:  hit = addr[MSB] & addr[MSB-1];
            LOCK_TOP_HALF: hit = addr[MSB];
            default:       hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wpc_sr_path.sv
// Status-write path: evaluates the pin lock at acceptance, holds the captured byte
// while the storage timer runs, and commits the nonvolatile fields when busy falls.
// Assumes sr_busy rises after a grant and falls once the storage write is done.
// The nonvolatile register has no reset; it starts at NV_INIT.
module wpc_sr_path
    import wpc_pkg::*;
#(
    parameter logic [STAT_W-1:0] NV_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrsr_req,
    input  logic              wel,
    input  logic [STAT_W-1:0] wdata,
    input  logic              pin_n,
    input  logic              busy,
    output nv_bits_t          nv,
    output logic              pending,
    output logic              commit,
    output logic              grant
);

    nv_bits_t nv_q = nv_from_byte(NV_INIT);
    nv_bits_t cap_q;
    logic     pend_q;
    logic     busy_q;
    logic     grant_q;
    logic     locked;
    logic     accept;

    assign locked = !pin_n && nv_q.plock;
    assign accept = wrsr_req && wel && !locked && !pend_q;
    assign commit = rst_n && pend_q && busy_q && !busy;

    // Track the pending write, the busy history and the grant pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            busy_q  <= 1'b0;
            grant_q <= 1'b0;
        end else begin
            busy_q  <= busy;
            grant_q <= accept;
            if (accept)      pend_q <= 1'b1;
            else if (commit) pend_q <= 1'b0;
        end
    end

    // Capture the proposed nonvolatile fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (accept) cap_q <= nv_from_byte(wdata);
    end

    // Nonvolatile store, kept across power-on, loaded only on commit.
    always_ff @(posedge clk) begin
        if (commit) nv_q <= cap_q;
    end

    assign nv      = nv_q;
    assign pending = pend_q;
    assign grant   = grant_q;

endmodule

// File: rtl/wprot_ctrl.sv
// Top: write-protection controller for a serial memory array and its status register.
// Assumes instruction strobes are one-cycle pulses already decoded and qualified.
module wprot_ctrl
    import wpc_pkg::*;
#(
    parameter int                ADDR_W  = 13,
    parameter logic [STAT_W-1:0] NV_INIT = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_sflag,
    input  logic              cmd_rflag,
    input  logic [STAT_W-1:0] sr_wdata,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              wp_n,
    input  logic              sr_busy,
    output logic [STAT_W-1:0] status_o,
    output logic              arr_wr_grant,
    output logic              sr_wr_grant
);

    nv_bits_t nv;
    logic     wel;
    logic     flag;
    logic     sr_pending;
    logic     sr_commit;
    logic     in_locked_range;
    logic     arr_accept;
    logic     arr_grant_q;
    logic     unused_wdata;

    assign unused_wdata = ^{sr_wdata[POS_FLAG], sr_wdata[POS_WEL], sr_wdata[0]};

    wpc_vol_latches u_vol (
        .clk      (clk),
        .rst_n    (por_n),
        .wel_set  (cmd_wren),
        .wel_clr  (cmd_wrdi | arr_accept | sr_commit),
        .flag_set (cmd_sflag),
        .flag_clr (cmd_rflag),
        .wel      (wel),
        .flag     (flag)
    );

    wpc_sr_path #(
        .NV_INIT (NV_INIT)
    ) u_sr (
        .clk      (clk),
        .rst_n    (por_n),
        .wrsr_req (cmd_wrsr),
        .wel      (wel),
        .wdata    (sr_wdata),
        .pin_n    (wp_n),
        .busy     (sr_busy),
        .nv       (nv),
        .pending  (sr_pending),
        .commit   (sr_commit),
        .grant    (sr_wr_grant)
    );

    wpc_range_check #(
        .ADDR_W (ADDR_W)
    ) u_range (
        .code (nv.lock),
        .addr (arr_addr),
        .hit  (in_locked_range)
    );

    assign arr_accept = arr_wr_req && wel && !in_locked_range && !sr_pending;

    // Register the array grant as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!por_n) arr_grant_q <= 1'b0;
        else        arr_grant_q <= arr_accept;
    end

    assign arr_wr_grant = arr_grant_q;

    // Assemble the status byte from volatile and nonvolatile fields.
    always_comb begin
        status_o                  = '0;
        status_o[POS_PLOCK]       = nv.plock;
        status_o[POS_WD_LO +: 2]  = nv.wdog;
        status_o[POS_FLAG]        = flag;
        status_o[POS_LK_LO +: 2]  = nv.lock;
        status_o[POS_WEL]         = wel;
    end

endmodule

// File: rtl/wprot_ctrl_checker.sv
// Checker: port-level temporal properties of the write-protection controller.
// Assumes the status byte layout of R10; range decode is rebuilt here from address bits.
module wprot_ctrl_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              por_n,
    input logic              cmd_wrdi,
    input logic              cmd_wrsr,
    input logic              cmd_rflag,
    input logic              arr_wr_req,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              wp_n,
    input logic [7:0]        status_o,
    input logic              arr_wr_grant,
    input logic              sr_wr_grant
);

    logic addr_locked;

    // Independent range decode: top quarter, top half or all.
    always_comb begin
        case (status_o[3:2])
            2'b00:   addr_locked = 1'b0;
            2'b01:   addr_locked = (arr_addr >= ADDR_W'(3 << (ADDR_W - 2)));
            2'b10:   addr_locked = (arr_addr >= ADDR_W'(1 << (ADDR_W - 1)));
            default: addr_locked = 1'b1;
        endcase
    end

    a_r3_arr_needs_wel: assert property (@(posedge clk) disable iff (!por_n)
        arr_wr_grant |-> $past(status_o[1]));

    a_r3_sr_needs_wel: assert property (@(posedge clk) disable iff (!por_n)
        sr_wr_grant |-> $past(status_o[1]));

    a_r4_locked_range_refused: assert property (@(posedge clk) disable iff (!por_n)
        (arr_wr_req && addr_locked) |=> !arr_wr_grant);

    a_r5_pin_lock_refused: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_wrsr && !wp_n && status_o[7]) |=> !sr_wr_grant);

    a_r9_wel_drops_on_grant: assert property (@(posedge clk) disable iff (!por_n)
        arr_wr_grant |-> !status_o[1]);

    a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!por_n)
        cmd_wrdi |=> !status_o[1]);

    a_r8_rflag_clears: assert property (@(posedge clk) disable iff (!por_n)
        cmd_rflag |=> !status_o[4]);

    a_r4_grant_single_cycle: assert property (@(posedge clk) disable iff (!por_n)
        arr_wr_grant |=> !arr_wr_grant);

endmodule

bind wprot_ctrl wprot_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .cmd_wrdi     (cmd_wrdi),
    .cmd_wrsr     (cmd_wrsr),
    .cmd_rflag    (cmd_rflag),
    .arr_wr_req   (arr_wr_req),
    .arr_addr     (arr_addr),
    .wp_n         (wp_n),
    .status_o     (status_o),
    .arr_wr_grant (arr_wr_grant),
    .sr_wr_grant  (sr_wr_grant)
);

// File: tb/wprot_ctrl_tb_top.sv
// Scoreboard bench: step() drives one cycle of stimulus and queues the expected
// outputs; the monitor pops one item per cycle just after the clock edge.
module wprot_ctrl_tb_top;

    localparam int AW = 13;
    localparam logic [4:0] C_NONE = 5'b00000;
    localparam logic [4:0] C_WREN = 5'b00001;
    localparam logic [4:0] C_WRDI = 5'b00010;
    localparam logic [4:0] C_WRSR = 5'b00100;
    localparam logic [4:0] C_SFL  = 5'b01000;
    localparam logic [4:0] C_RFL  = 5'b10000;

    typedef struct {
        logic       a;
        logic       s;
        logic [7:0] st;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic [4:0]    cmd = '0;
    logic [7:0]    din = '0;
    logic          areq = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wp_n = 1'b1;
    logic          busy = 1'b0;
    logic [7:0]    status;
    logic          agnt;
    logic          sgnt;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    wprot_ctrl #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .cmd_wren     (cmd[0]),
        .cmd_wrdi     (cmd[1]),
        .cmd_wrsr     (cmd[2]),
        .cmd_sflag    (cmd[3]),
        .cmd_rflag    (cmd[4]),
        .sr_wdata     (din),
        .arr_wr_req   (areq),
        .arr_addr     (addr),
        .wp_n         (wp_n),
        .sr_busy      (busy),
        .status_o     (status),
        .arr_wr_grant (agnt),
        .sr_wr_grant  (sgnt)
    );

    task automatic step(input logic p, input logic [4:0] c, input logic [7:0] d,
                        input logic ar, input logic [AW-1:0] ad, input logic w,
                        input logic b, input logic ea, input logic es,
                        input logic [7:0] est, input string tag);
        exp_t e;
        @(negedge clk);
        por_n = p; cmd = c; din = d; areq = ar; addr = ad; wp_n = w; busy = b;
        e.a = ea; e.s = es; e.st = est; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one queued expectation per clock, 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (agnt !== e.a || sgnt !== e.s || status !== e.st) begin
                    errors++;
                    $display("FAIL %s: got arr=%0b sr=%0b status=%02h, expected arr=%0b sr=%0b status=%02h",
                             e.tag, agnt, sgnt, status, e.a, e.s, e.st);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(0, C_NONE, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h00, "R1 reset state");
        step(0, C_WREN, 8'h00, 1, 'h0000, 1, 0, 0, 0, 8'h00, "R1 strobes ignored in reset");
        step(1, C_NONE, 8'h00, 1, 'h0000, 1, 0, 0, 0, 8'h00, "R3 array refused without latch");
        step(1, C_WRSR, 8'h84, 0, 'h0000, 1, 0, 0, 0, 8'h00, "R3 status refused without latch");
        step(1, C_WREN, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h02, "R2 latch set, R10 bit1");
        step(1, C_WREN | C_WRDI, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h00, "R2 disable wins");
        step(1, C_WREN, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h02, "R2 latch set again");
        step(1, C_NONE, 8'h00, 1, 'h0000, 1, 0, 1, 0, 8'h00, "R4 no lock grant, R9 latch cleared");
        step(1, C_SFL, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h10, "R8 flag set, R10 bit4");
        step(1, C_SFL | C_RFL, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h00, "R8 clear wins");
        step(1, C_SFL, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h10, "R8 flag set again");
        step(1, C_WREN, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h12, "R2 latch with flag");
        step(1, C_WRSR, 8'h6E, 0, 'h0000, 1, 0, 0, 1, 8'h12, "R5 status grant");
        step(1, C_NONE, 8'h00, 0, 'h0000, 1, 1, 0, 0, 8'h12, "R7 no change while busy");
        step(1, C_NONE, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h7C, "R7 commit keeps flag, R9 latch cleared");
        step(1, C_WREN, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h7E, "R2 latch set");
        step(1, C_NONE, 8'h00, 1, 'h0000, 1, 0, 0, 0, 8'h7E, "R4 code 11 locks 0x0000");
        step(1, C_NONE, 8'h00, 1, 'h1FFF, 1, 0, 0, 0, 8'h7E, "R4 code 11 locks 0x1FFF");
        step(1, C_WRSR, 8'h84, 0, 'h0000, 1, 0, 0, 1, 8'h7E, "R5 grant before pin-lock set");
        step(1, C_NONE, 8'h00, 0, 'h0000, 0, 1, 0, 0, 8'h7E, "R6 pin falls in flight");
        step(1, C_NONE, 8'h00, 0, 'h0000, 0, 0, 0, 0, 8'h94, "R6 in-flight write completes");
        step(1, C_WREN, 8'h00, 0, 'h0000, 0, 0, 0, 0, 8'h96, "R2 latch set");
        step(1, C_WRSR, 8'h00, 0, 'h0000, 0, 0, 0, 0, 8'h96, "R5 pin low and lock bit refused");
        step(1, C_NONE, 8'h00, 1, 'h1800, 0, 0, 0, 0, 8'h96, "R4 code 01 locks 0x1800");
        step(1, C_NONE, 8'h00, 1, 'h17FF, 0, 0, 1, 0, 8'h94, "R4 code 01 frees 0x17FF");
        step(1, C_WREN, 8'h00, 0, 'h0000, 0, 0, 0, 0, 8'h96, "R2 latch set");
        step(1, C_WRSR, 8'h08, 0, 'h0000, 1, 0, 0, 1, 8'h96, "R5 pin high overrides lock bit");
        step(1, C_WRSR, 8'h84, 0, 'h0000, 1, 1, 0, 0, 8'h96, "R11 status refused while pending");
        step(1, C_NONE, 8'h00, 1, 'h0000, 1, 1, 0, 0, 8'h96, "R11 array refused while pending");
        step(1, C_NONE, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h18, "R7 commit code 10");
        step(1, C_WREN, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h1A, "R2 latch set");
        step(1, C_NONE, 8'h00, 1, 'h1000, 1, 0, 0, 0, 8'h1A, "R4 code 10 locks 0x1000");
        step(1, C_NONE, 8'h00, 1, 'h0FFF, 1, 0, 1, 0, 8'h18, "R4 code 10 frees 0x0FFF");
        step(1, C_WREN, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h1A, "R2 latch set");
        step(0, C_NONE, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h08, "R1 power-on keeps nonvolatile bits");
        step(1, C_NONE, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h08, "R1 state after power-on");
        step(1, C_WREN, 8'h00, 0, 'h0000, 0, 0, 0, 0, 8'h0A, "R2 latch set");
        step(1, C_WRSR, 8'h60, 0, 'h0000, 0, 0, 0, 1, 8'h0A, "R5 lock bit 0 ignores pin");
        step(1, C_NONE, 8'h00, 0, 'h0000, 0, 1, 0, 0, 8'h0A, "R7 hold while busy");
        step(1, C_NONE, 8'h00, 0, 'h0000, 0, 0, 0, 0, 8'h60, "R7 watchdog bits, R10 layout");
        step(1, C_NONE, 8'h00, 0, 'h0000, 1, 0, 0, 0, 8'h60, "R10 idle hold");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule